// File: doc/BRIEF.md
# Segmented Bus Write Guard

This block sits between a group of bus masters and a memory or peripheral region and decides, request by request, whether a write may go on. Four programmable address segments each carry a mask of masters allowed to write inside them. A second mode guards the devices behind a peripheral bridge: each device index in a peripheral window has its own mask of masters allowed to write to it. Reads are never checked.

Requests arrive on a valid/ready port carrying address, a write flag and the master index. Allowed requests are forwarded unchanged on a valid/ready port to the downstream target. A refused write is taken off the request port, is never forwarded, and completes with a two-cycle bus ERROR response. The unit raises no interrupt; a separate bus status monitor is expected to watch the error pins. Back-pressure rules: an allowed request is accepted only in a cycle where the downstream side is ready, so `req_ready` follows `fwd_ready` and `fwd_*` mirror `req_*` while `fwd_valid` is high. A refused write is accepted without waiting on `fwd_ready`. While the error response runs, `req_ready` is low. The upstream side must hold a request stable until it is accepted.

Configuration goes through a separate register port that is always reachable and never guarded by the unit itself. Writes that would set read-only bits, or that place a bound outside the legal segment window, are dropped as a whole.

Top module: `wp_guard`

## Requirements
- R1: After reset every segment and the peripheral gate are disabled, all registers read as zero, and every write is forwarded.
- R2: An enabled segment matches when lo <= address <= hi, both bounds inclusive and word aligned. The register map places the control register at index 0, with segment enables in bits 3:0 and the peripheral gate enable in bit 8. Segment s has its low bound at index 1+2s, its high bound at index 2+2s, and its master mask at index 9+s.
- R3: A write inside a matching segment is forwarded when bit m of that segment's mask is 1, where m is the requesting master index.
- R4: When enabled segments overlap, a write is refused if any matching segment has a 0 in the mask bit for that master.
- R5: A refused write is accepted (`req_ready` high), is not forwarded, and is followed by one cycle of `err_hready`=0 with `err_hresp`=1, then one cycle of `err_hready`=1 with `err_hresp`=1, then the idle state `err_hready`=1 with `err_hresp`=0. `req_ready` is low during both error cycles.
- R6: Reads are forwarded whatever the segment and device settings.
- R7: A bound write whose value lies outside [WIN_BASE, WIN_LAST] is ignored and the bound keeps its old value.
- R8: A configuration write is ignored if it sets a read-only bit. The read-only bits are control bits other than 3:0 and 8, bound bits 1:0, and mask bits at or above the master count.
- R9: When the gate is enabled, a write to device d of the peripheral window is refused unless bit m of the mask at register index 16+d is 1. Device d spans PER_BASE + d*2^DEV_SHIFT over 2^DEV_SHIFT bytes. Addresses beyond PER_LAST are not gated.
- R10: Device SELF_DEV (default 7) is never refused, whatever its mask.
- R11: With `fwd_ready` low, an allowed request stays on `fwd_*` with `req_ready` low until the downstream side is ready.
- R12: A configuration write in the same cycle that a request is accepted does not affect that request; it applies from the next request on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken this cycle |
| req_addr | input | ADDR_W | Byte address of the request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_master | input | MID_W | Index of the requesting master |
| fwd_valid | output | 1 | Allowed request offered downstream |
| fwd_ready | input | 1 | Downstream can take the request |
| fwd_addr | output | ADDR_W | Forwarded address |
| fwd_write | output | 1 | Forwarded write flag |
| fwd_master | output | MID_W | Forwarded master index |
| err_hready | output | 1 | Error response ready phase (low in first error cycle) |
| err_hresp | output | 1 | 1 = ERROR response in progress |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration register index |
| cfg_wdata | input | ADDR_W | Configuration write data |
| cfg_rdata | output | ADDR_W | Contents of the register at cfg_addr |

## Verification
A request can be accepted in the same cycle that a configuration write lands, so the permission decision and the register update can fall on one clock edge. The bench provokes this by refusing master 1 in segment 0. It then drives a write from master 1 together with a mask write that would permit it, both in the same cycle. The request must still end in the ERROR sequence, and an identical write issued right after it must be forwarded. Separately, refused and allowed writes are interleaved with reads and held-back downstream cycles. This shows that the error sequence never overlaps a forwarded request.

// File: rtl/wp_pkg.sv
package wp_pkg;
  localparam int NUM_SEG       = 4;
  localparam int CFG_AW        = 5;
  localparam int REG_CTRL      = 0;
  localparam int REG_BOUND0    = 1;
  localparam int REG_ALLOW0    = 9;
  localparam int REG_DEV0      = 16;
  localparam int CTRL_GATE_BIT = 8;

  typedef enum logic [1:0] {
    RSP_IDLE     = 2'd0,
    RSP_ERR_LOW  = 2'd1,
    RSP_ERR_HIGH = 2'd2
  } rsp_state_t;
endpackage

// File: rtl/wp_regs.sv
module wp_regs
  import wp_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int NUM_MASTERS = 4,
  parameter int NUM_DEV     = 8,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'h4000_0000,
  parameter logic [ADDR_W-1:0] WIN_LAST = 32'h4FFF_FFFF
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 cfg_we,
  input  logic [CFG_AW-1:0]                    cfg_addr,
  input  logic [ADDR_W-1:0]                    cfg_wdata,
  output logic [ADDR_W-1:0]                    cfg_rdata,
  output logic [NUM_SEG-1:0]                   seg_en,
  output logic                                 gate_en,
  output logic [NUM_SEG-1:0][ADDR_W-1:0]       seg_lo,
  output logic [NUM_SEG-1:0][ADDR_W-1:0]       seg_hi,
  output logic [NUM_SEG-1:0][NUM_MASTERS-1:0]  seg_allow,
  output logic [NUM_DEV-1:0][NUM_MASTERS-1:0]  dev_allow
);
  localparam logic [ADDR_W-1:0] CTRL_RW =
    {{(ADDR_W-NUM_SEG){1'b0}}, {NUM_SEG{1'b1}}} | (ADDR_W'(1) << CTRL_GATE_BIT);
  localparam logic [ADDR_W-1:0] MASK_RW =
    {{(ADDR_W-NUM_MASTERS){1'b0}}, {NUM_MASTERS{1'b1}}};

  logic ctrl_ok, bound_ok, mask_ok;

  assign ctrl_ok  = (cfg_wdata & ~CTRL_RW) == '0;
  assign mask_ok  = (cfg_wdata & ~MASK_RW) == '0;
  assign bound_ok = (cfg_wdata[1:0] == 2'b00) &&
                    (cfg_wdata >= WIN_BASE) && (cfg_wdata <= WIN_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_en    <= '0;
      gate_en   <= 1'b0;
      seg_lo    <= '0;
      seg_hi    <= '0;
      seg_allow <= '0;
      dev_allow <= '0;
    end else if (cfg_we) begin
      if (cfg_addr == CFG_AW'(REG_CTRL) && ctrl_ok) begin
        seg_en  <= cfg_wdata[NUM_SEG-1:0];
        gate_en <= cfg_wdata[CTRL_GATE_BIT];
      end
      for (int s = 0; s < NUM_SEG; s++) begin
        if (cfg_addr == CFG_AW'(REG_BOUND0 + 2*s) && bound_ok)
          seg_lo[s] <= cfg_wdata;
        if (cfg_addr == CFG_AW'(REG_BOUND0 + 2*s + 1) && bound_ok)
          seg_hi[s] <= cfg_wdata;
        if (cfg_addr == CFG_AW'(REG_ALLOW0 + s) && mask_ok)
          seg_allow[s] <= cfg_wdata[NUM_MASTERS-1:0];
      end
      for (int d = 0; d < NUM_DEV; d++) begin
        if (cfg_addr == CFG_AW'(REG_DEV0 + d) && mask_ok)
          dev_allow[d] <= cfg_wdata[NUM_MASTERS-1:0];
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_addr == CFG_AW'(REG_CTRL)) begin
      cfg_rdata[NUM_SEG-1:0]   = seg_en;
      cfg_rdata[CTRL_GATE_BIT] = gate_en;
    end
    for (int s = 0; s < NUM_SEG; s++) begin
      if (cfg_addr == CFG_AW'(REG_BOUND0 + 2*s))     cfg_rdata = seg_lo[s];
      if (cfg_addr == CFG_AW'(REG_BOUND0 + 2*s + 1)) cfg_rdata = seg_hi[s];
      if (cfg_addr == CFG_AW'(REG_ALLOW0 + s))
        cfg_rdata[NUM_MASTERS-1:0] = seg_allow[s];
    end
    for (int d = 0; d < NUM_DEV; d++) begin
      if (cfg_addr == CFG_AW'(REG_DEV0 + d))
        cfg_rdata[NUM_MASTERS-1:0] = dev_allow[d];
    end
  end
endmodule

// File: rtl/wp_seg_match.sv
module wp_seg_match #(
  parameter int ADDR_W      = 32,
  parameter int NUM_MASTERS = 4,
  parameter int MID_W       = 2
) (
  input  logic                   en,
  input  logic [ADDR_W-1:0]      lo,
  input  logic [ADDR_W-1:0]      hi,
  input  logic [NUM_MASTERS-1:0] allow,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [MID_W-1:0]       master,
  output logic                   deny
);
  logic hit;
  logic permitted;

  assign hit = en && (addr >= lo) && (addr <= hi);

  always_comb begin
    permitted = 1'b0;
    for (int m = 0; m < NUM_MASTERS; m++)
      if (master == MID_W'(m)) permitted = allow[m];
  end

  assign deny = hit && !permitted;
endmodule

// File: rtl/wp_dev_gate.sv
module wp_dev_gate #(
  parameter int ADDR_W      = 32,
  parameter int NUM_MASTERS = 4,
  parameter int MID_W       = 2,
  parameter int NUM_DEV     = 8,
  parameter int DEV_SHIFT   = 12,
  parameter int SELF_DEV    = 7,
  parameter logic [ADDR_W-1:0] PER_BASE = 32'h8000_0000,
  parameter logic [ADDR_W-1:0] PER_LAST = 32'h8000_7FFF
) (
  input  logic                                gate_en,
  input  logic [NUM_DEV-1:0][NUM_MASTERS-1:0] dev_allow,
  input  logic [ADDR_W-1:0]                   addr,
  input  logic [MID_W-1:0]                    master,
  output logic                                deny
);
  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(1) << DEV_SHIFT;

  logic [NUM_DEV-1:0] dev_deny;

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    localparam logic [ADDR_W-1:0] DEV_LO = PER_BASE + ADDR_W'(d) * SPAN;
    localparam logic [ADDR_W-1:0] DEV_HI = DEV_LO + SPAN - ADDR_W'(1);
    logic in_dev;
    logic permitted;

    assign in_dev = (addr >= DEV_LO) && (addr <= DEV_HI) && (addr <= PER_LAST);

    always_comb begin
      permitted = 1'b0;
      for (int m = 0; m < NUM_MASTERS; m++)
        if (master == MID_W'(m)) permitted = dev_allow[d][m];
    end

    if (d == SELF_DEV) begin : g_self
      assign dev_deny[d] = 1'b0;
    end else begin : g_other
      assign dev_deny[d] = gate_en && in_dev && !permitted;
    end
  end

  assign deny = |dev_deny;
endmodule

// File: rtl/wp_err_seq.sv
module wp_err_seq
  import wp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic take_deny,
  output logic idle,
  output logic err_hready,
  output logic err_hresp
);
  rsp_state_t state, state_nx;

  always_comb begin
    state_nx = state;
    case (state)
      RSP_IDLE:     if (take_deny) state_nx = RSP_ERR_LOW;
      RSP_ERR_LOW:  state_nx = RSP_ERR_HIGH;
      RSP_ERR_HIGH: state_nx = RSP_IDLE;
      default:      state_nx = RSP_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= RSP_IDLE;
    else        state <= state_nx;
  end

  assign idle       = (state == RSP_IDLE);
  assign err_hready = (state != RSP_ERR_LOW);
  assign err_hresp  = (state == RSP_ERR_LOW) || (state == RSP_ERR_HIGH);
endmodule

// File: rtl/wp_guard.sv
module wp_guard
  import wp_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int NUM_MASTERS = 4,
  parameter int NUM_DEV     = 8,
  parameter int DEV_SHIFT   = 12,
  parameter int SELF_DEV    = 7,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'h4000_0000,
  parameter logic [ADDR_W-1:0] WIN_LAST = 32'h4FFF_FFFF,
  parameter logic [ADDR_W-1:0] PER_BASE = 32'h8000_0000,
  parameter logic [ADDR_W-1:0] PER_LAST = 32'h8000_7FFF,
  localparam int MID_W = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [MID_W-1:0]  req_master,
  output logic              fwd_valid,
  input  logic              fwd_ready,
  output logic [ADDR_W-1:0] fwd_addr,
  output logic              fwd_write,
  output logic [MID_W-1:0]  fwd_master,
  output logic              err_hready,
  output logic              err_hresp,
  input  logic              cfg_we,
  input  logic [4:0]        cfg_addr,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] cfg_rdata
);
  logic [NUM_SEG-1:0]                  seg_en;
  logic                                gate_en;
  logic [NUM_SEG-1:0][ADDR_W-1:0]      seg_lo, seg_hi;
  logic [NUM_SEG-1:0][NUM_MASTERS-1:0] seg_allow;
  logic [NUM_DEV-1:0][NUM_MASTERS-1:0] dev_allow;
  logic [NUM_SEG-1:0]                  seg_deny;
  logic                                dev_deny;
  logic                                refuse;
  logic                                rsp_idle;

  wp_regs #(
    .ADDR_W(ADDR_W), .NUM_MASTERS(NUM_MASTERS), .NUM_DEV(NUM_DEV),
    .WIN_BASE(WIN_BASE), .WIN_LAST(WIN_LAST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata),
    .seg_en(seg_en), .gate_en(gate_en), .seg_lo(seg_lo), .seg_hi(seg_hi),
    .seg_allow(seg_allow), .dev_allow(dev_allow)
  );

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    wp_seg_match #(
      .ADDR_W(ADDR_W), .NUM_MASTERS(NUM_MASTERS), .MID_W(MID_W)
    ) u_match (
      .en(seg_en[s]), .lo(seg_lo[s]), .hi(seg_hi[s]), .allow(seg_allow[s]),
      .addr(req_addr), .master(req_master), .deny(seg_deny[s])
    );
  end

  wp_dev_gate #(
    .ADDR_W(ADDR_W), .NUM_MASTERS(NUM_MASTERS), .MID_W(MID_W),
    .NUM_DEV(NUM_DEV), .DEV_SHIFT(DEV_SHIFT), .SELF_DEV(SELF_DEV),
    .PER_BASE(PER_BASE), .PER_LAST(PER_LAST)
  ) u_gate (
    .gate_en(gate_en), .dev_allow(dev_allow),
    .addr(req_addr), .master(req_master), .deny(dev_deny)
  );

  // Reads bypass every check; only writes can be refused.
  assign refuse = req_write && ((|seg_deny) || dev_deny);

  wp_err_seq u_err (
    .clk(clk), .rst_n(rst_n),
    .take_deny(req_valid && rsp_idle && refuse),
    .idle(rsp_idle), .err_hready(err_hready), .err_hresp(err_hresp)
  );

  assign req_ready  = rsp_idle && (refuse || fwd_ready);
  assign fwd_valid  = req_valid && rsp_idle && !refuse;
  assign fwd_addr   = req_addr;
  assign fwd_write  = req_write;
  assign fwd_master = req_master;
endmodule

// File: rtl/wp_guard_sva.sv
module wp_guard_sva #(
  parameter int ADDR_W = 32,
  parameter int MID_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic              fwd_valid,
  input logic              fwd_ready,
  input logic              err_hready,
  input logic              err_hresp
);
  // R5: an accepted but unforwarded write opens the error response
  assert_refusal_opens_error_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_write && !fwd_valid |=> !err_hready && err_hresp);

  // R5: the low ready phase is followed by the high ready phase with ERROR kept
  assert_error_second_phase_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !err_hready |=> err_hready && err_hresp);

  // R5: the error response always starts with ready low
  assert_error_starts_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_hresp) |-> !err_hready);

  // R5: nothing is taken or forwarded while the error response runs
  assert_error_blocks_port_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err_hresp |-> !req_ready && !fwd_valid);

  // R6: an accepted read is always handed downstream
  assert_read_forwarded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_write && req_ready |-> fwd_valid);

  // R11: a forwarded request is only taken when the sink is ready
  assert_no_drop_on_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid && req_ready |-> fwd_ready);
endmodule

bind wp_guard wp_guard_sva #(.ADDR_W(ADDR_W), .MID_W(MID_W)) u_guard_sva (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .fwd_valid(fwd_valid), .fwd_ready(fwd_ready),
  .err_hready(err_hready), .err_hresp(err_hresp)
);

// File: tb/test_wp_guard.sv
module test_wp_guard;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [1:0]  req_master = '0;
  logic        fwd_valid;
  logic        fwd_ready = 1'b1;
  logic [31:0] fwd_addr;
  logic        fwd_write;
  logic [1:0]  fwd_master;
  logic        err_hready;
  logic        err_hresp;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wp_guard i_wp_guard (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .req_master(req_master),
    .fwd_valid(fwd_valid), .fwd_ready(fwd_ready), .fwd_addr(fwd_addr),
    .fwd_write(fwd_write), .fwd_master(fwd_master),
    .err_hready(err_hready), .err_hresp(err_hresp),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input int idx, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 5'(idx); cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_expect(input int idx, input logic [31:0] exp, input string tag);
    @(negedge clk);
    cfg_addr = 5'(idx);
    #1;
    check(cfg_rdata == exp, tag, cfg_rdata, exp);
  endtask

  // Checks the error tail after a refused request has just been accepted.
  task automatic expect_error_tail(input string tag);
    @(negedge clk); req_valid = 1'b0; #1;
    check(!err_hready && err_hresp && !req_ready, {tag, " err phase1"},
          {29'd0, err_hready, err_hresp, req_ready}, 32'h2);
    @(negedge clk); #1;
    check(err_hready && err_hresp && !req_ready, {tag, " err phase2"},
          {29'd0, err_hready, err_hresp, req_ready}, 32'h6);
    @(negedge clk); #1;
    check(err_hready && !err_hresp, {tag, " back to idle"},
          {30'd0, err_hready, err_hresp}, 32'h2);
  endtask

  task automatic access(input logic [31:0] a, input int m, input bit wr,
                        input bit exp_err, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_master = 2'(m); req_write = wr;
    fwd_ready = 1'b1;
    #1;
    check(fwd_valid == !exp_err && req_ready, {tag, " decision"},
          {30'd0, fwd_valid, req_ready}, {30'd0, !exp_err, 1'b1});
    if (!exp_err)
      check(fwd_addr == a && fwd_write == wr, {tag, " forwarded fields"}, fwd_addr, a);
    if (exp_err) expect_error_tail(tag);
    else begin
      @(negedge clk); req_valid = 1'b0; #1;
      check(err_hready && !err_hresp, {tag, " no error"},
            {30'd0, err_hready, err_hresp}, 32'h2);
    end
  endtask

  task automatic t_reset;
    cfg_expect(0, 32'h0, "R1 control after reset");
    cfg_expect(1, 32'h0, "R1 seg0 low after reset");
    cfg_expect(9, 32'h0, "R1 seg0 mask after reset");
    access(32'h4000_1000, 2, 1, 0, "R1 write passes after reset");
    access(32'h8000_2000, 1, 1, 0, "R1 peripheral write passes after reset");
  endtask

  task automatic t_segment;
    cfg_write(1, 32'h4000_1000);
    cfg_write(2, 32'h4000_1FFC);
    cfg_write(9, 32'h1);
    cfg_write(0, 32'h1);
    access(32'h4000_1000, 1, 1, 1, "R2 low bound inclusive");
    access(32'h4000_1FFC, 1, 1, 1, "R2 high bound inclusive");
    access(32'h4000_0FFC, 1, 1, 0, "R2 word below segment");
    access(32'h4000_2000, 1, 1, 0, "R2 word above segment");
  endtask

  task automatic t_master;
    access(32'h4000_1800, 0, 1, 0, "R3 permitted master");
    access(32'h4000_1800, 3, 1, 1, "R3 other master refused");
  endtask

  task automatic t_overlap;
    cfg_write(3, 32'h4000_1800);
    cfg_write(4, 32'h4000_27FC);
    cfg_write(10, 32'h3);
    cfg_write(0, 32'h3);
    access(32'h4000_1900, 1, 1, 1, "R4 overlap one segment denies");
    access(32'h4000_2400, 1, 1, 0, "R4 second segment alone allows");
    access(32'h4000_2400, 2, 1, 1, "R4 second segment denies master2");
  endtask

  task automatic t_read;
    access(32'h4000_1000, 1, 0, 0, "R6 read inside segment");
    access(32'h4000_2400, 3, 0, 0, "R6 read other master");
  endtask

  task automatic t_bounds;
    cfg_write(5, 32'h4100_0000);
    cfg_expect(5, 32'h4100_0000, "R7 bound in window kept");
    cfg_write(5, 32'h3000_0000);
    cfg_expect(5, 32'h4100_0000, "R7 bound below window ignored");
    cfg_write(6, 32'h5000_0000);
    cfg_expect(6, 32'h0, "R7 bound above window ignored");
  endtask

  task automatic t_readonly;
    cfg_write(0, 32'h0000_0013);
    cfg_expect(0, 32'h3, "R8 control with read-only bit ignored");
    cfg_write(1, 32'h4000_0002);
    cfg_expect(1, 32'h4000_1000, "R8 unaligned bound ignored");
    cfg_write(9, 32'h0000_0011);
    cfg_expect(9, 32'h1, "R8 mask with high bit ignored");
    access(32'h4000_1000, 1, 1, 1, "R8 protection unchanged");
  endtask

  task automatic t_periph;
    cfg_write(18, 32'h1);
    cfg_write(0, 32'h103);
    access(32'h8000_2000, 1, 1, 1, "R9 device2 master1 refused");
    access(32'h8000_2FFC, 0, 1, 0, "R9 device2 master0 allowed");
    access(32'h8000_3000, 0, 1, 1, "R9 device3 empty mask refused");
    access(32'h8000_8000, 1, 1, 0, "R9 past peripheral window");
    access(32'h8000_7000, 1, 1, 0, "R10 own device never refused");
    cfg_write(0, 32'h3);
    access(32'h8000_2000, 1, 1, 0, "R9 gate off allows");
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    fwd_ready = 1'b0;
    req_valid = 1'b1; req_addr = 32'h4000_0100; req_master = 2'd1; req_write = 1'b1;
    for (int i = 0; i < 3; i++) begin
      #1;
      check(fwd_valid && !req_ready && fwd_addr == 32'h4000_0100,
            "R11 held while sink stalls", {30'd0, fwd_valid, req_ready}, 32'h2);
      @(negedge clk);
    end
    fwd_ready = 1'b1;
    #1;
    check(fwd_valid && req_ready, "R11 taken when sink ready",
          {30'd0, fwd_valid, req_ready}, 32'h3);
    @(negedge clk); req_valid = 1'b0;
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 5'd9; cfg_wdata = 32'h3;
    req_valid = 1'b1; req_addr = 32'h4000_1000; req_master = 2'd1; req_write = 1'b1;
    #1;
    check(!fwd_valid && req_ready, "R12 old config decides",
          {30'd0, fwd_valid, req_ready}, 32'h1);
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0; #1;
    check(!err_hready && err_hresp, "R12 error despite same-cycle update",
          {30'd0, err_hready, err_hresp}, 32'h1);
    @(negedge clk);
    @(negedge clk);
    access(32'h4000_1000, 1, 1, 0, "R12 new config applies next");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_segment();
    t_master();
    t_overlap();
    t_read();
    t_bounds();
    t_readonly();
    t_periph();
    t_backpressure();
    t_same_cycle();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule